// File: doc/BRIEF.md
# Regular-Opcode Operand and Length Decoder

This block is a purely combinational decoder for the first byte of an instruction in an 8-bit, accumulator-centred instruction set. From a single opcode byte it reports:

- which of the sixteen regular operations the byte encodes;
- where the primary operand comes from, and which register supplies it;
- whether the result is written to a directly addressed memory location;
- how many bytes the whole instruction occupies;
- which status flags the operation is allowed to change.

The regular grid has sixteen operations (the high nibble) crossed with twelve operand modes (the low nibble). The grid is not orthogonal:

- Some cells in low-nibble column 4 mean "accumulator" rather than "immediate".
- Three logical operations borrow columns 2 and 3 for forms that write to memory.
- A set of cells carries no regular instruction at all.

Any byte that is not a regular instruction is flagged for a separate irregular decoder. A fetch unit uses the length output to know how many operand bytes to collect. An execute stage uses the class, mode and flag outputs to steer the datapath.

Top module: `opc_grid_decoder`

## Requirements
- R1: `op_class_o` equals the opcode's high nibble for every valid opcode. The codes are 0 INC, 1 DEC, 2 ADD, 3 ADD-with-carry, 4 OR, 5 AND, 6 XOR, 7 move-immediate-to-operand, 8 move-to-direct, 9 subtract-with-borrow, A move-from-direct, B compare-and-jump, C exchange, D decrement-and-jump, E move-to-accumulator, F move-from-accumulator.
- R2: When the low nibble is 8..F, `src_mode_o` is 4 (register) and `reg_sel_o` equals the low nibble minus 8. When the low nibble is 6 or 7, `src_mode_o` is 3 (indirect) and `reg_sel_o` equals the low nibble minus 6.
- R3: When the low nibble is 5, `src_mode_o` is 2 (direct address byte) and `reg_sel_o` is 0.
- R4: When the low nibble is 4, `src_mode_o` is 0 (accumulator) for high nibbles 0, 1 and 7. It is 1 (immediate byte) for high nibbles 2, 3, 4, 5, 6, 9 and B.
- R5: Opcodes 0x42, 0x52 and 0x62 are valid, with `src_mode_o`=0, `dst_mem_o`=1 and `length_o`=2. Opcodes 0x43, 0x53 and 0x63 are valid, with `src_mode_o`=1, `dst_mem_o`=1 and `length_o`=3.
- R6: Opcodes 0x84, 0xA4, 0xA5, 0xC4, 0xD4, 0xD6, 0xD7, 0xE4 and 0xF4 are not valid. Neither is any other opcode with low nibble 0..3 apart from those in R5.
- R7: `length_o` is 1, plus 1 for a direct or immediate primary operand, plus 1 for each extra byte the operation carries:
  - an immediate for class 7;
  - a direct address for classes 8 and A, and for the R5 forms;
  - a relative offset for classes B and D;
  - a second immediate for class B in register or indirect mode.

  Class B is therefore always 3, and 0x85 is 3.
- R8: `dst_mem_o` is 1 for class 8, for the R5 forms, and for classes 0, 1, 7, C, D and F in direct mode. It is 0 for all other opcodes.
- R9: `flags_all_o` is 1 exactly for valid classes 2, 3 and 9. `carry_only_o` is 1 exactly for valid class B.
- R10: `valid_o` and `irregular_o` are always complementary. For an opcode that is not valid, all other outputs are 0, including `length_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 8 | Opcode byte to decode |
| valid_o | output | 1 | Byte is a regular-grid instruction |
| irregular_o | output | 1 | Byte belongs to the irregular decoder |
| op_class_o | output | 4 | Operation class code |
| src_mode_o | output | 3 | Primary operand mode: 0 acc, 1 imm, 2 direct, 3 indirect, 4 register |
| reg_sel_o | output | 3 | Register index for register or indirect mode |
| dst_mem_o | output | 1 | Result written to a direct memory address |
| length_o | output | 2 | Instruction length in bytes (0 when not valid) |
| flags_all_o | output | 1 | Operation updates all arithmetic flags |
| carry_only_o | output | 1 | Operation updates the carry flag only |

## Verification
The cells hardest to reach are the exceptions packed into columns 2 to 5: the nine holes, the six memory-destination forms, and the column-4 cells whose meaning flips between accumulator and immediate. A random opcode hits any one of them with a probability of only a few percent. The bench therefore sweeps all 256 byte values in order, so that every such exception is visited deterministically. It then adds seeded random bytes and re-visits the exception cells in a directed list. Each result is compared with an expected value built from the requirements alone.

// File: rtl/opc_grid_pkg.sv
package opc_grid_pkg;

    localparam int OPC_W  = 8;
    localparam int NIB_W  = OPC_W / 2;
    localparam int REG_W  = 3;
    localparam int LEN_W  = 2;
    localparam int SUM_W  = LEN_W + 1;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_ACC = 3'd0,
        MODE_IMM = 3'd1,
        MODE_DIR = 3'd2,
        MODE_IND = 3'd3,
        MODE_REG = 3'd4
    } opnd_mode_e;

    typedef enum logic [NIB_W-1:0] {
        CLS_INC  = 4'h0,
        CLS_DEC  = 4'h1,
        CLS_ADD  = 4'h2,
        CLS_ADDC = 4'h3,
        CLS_OR   = 4'h4,
        CLS_AND  = 4'h5,
        CLS_XOR  = 4'h6,
        CLS_MVI  = 4'h7,
        CLS_MVTD = 4'h8,
        CLS_SUBB = 4'h9,
        CLS_MVFD = 4'hA,
        CLS_CJMP = 4'hB,
        CLS_XCHG = 4'hC,
        CLS_DJMP = 4'hD,
        CLS_MVTA = 4'hE,
        CLS_MVFA = 4'hF
    } op_cls_e;

    typedef struct packed {
        opnd_mode_e        mode;
        logic [REG_W-1:0]  rsel;
    } opnd_info_t;

    typedef struct packed {
        logic              valid;
        logic              memform;
        logic              dst_mem;
        logic              flags_all;
        logic              carry_only;
    } grid_info_t;

    // OR, AND, XOR own the memory-destination columns 2 and 3
    function automatic logic is_logic_cls(input op_cls_e c);
        return (c == CLS_OR) || (c == CLS_AND) || (c == CLS_XOR);
    endfunction

    // operations whose column-4 cell names the accumulator
    function automatic logic col4_is_acc(input op_cls_e c);
        return (c == CLS_INC) || (c == CLS_DEC) || (c == CLS_MVI);
    endfunction

    // regular cells that hold no regular instruction
    function automatic logic is_hole(input op_cls_e c, input logic [NIB_W-1:0] lo);
        logic h;
        h = 1'b0;
        case (c)
            CLS_MVTD, CLS_XCHG, CLS_MVTA, CLS_MVFA: h = (lo == 4'h4);
            CLS_MVFD: h = (lo == 4'h4) || (lo == 4'h5);
            CLS_DJMP: h = (lo == 4'h4) || (lo == 4'h6) || (lo == 4'h7);
            default:  h = 1'b0;
        endcase
        return h;
    endfunction

    // operations whose operand is written in direct mode
    function automatic logic writes_operand(input op_cls_e c);
        return (c == CLS_INC) || (c == CLS_DEC) || (c == CLS_MVI) ||
               (c == CLS_XCHG) || (c == CLS_DJMP) || (c == CLS_MVFA);
    endfunction

endpackage

// File: rtl/opc_mode_dec.sv
module opc_mode_dec
    import opc_grid_pkg::*;
(
    input  op_cls_e           cls_i,
    input  logic [NIB_W-1:0]  lo_i,
    output opnd_info_t        info_o
);

    localparam int REG_BASE = 8;
    localparam int IND_BASE = 6;

    always_comb begin
        info_o.mode = MODE_ACC;
        info_o.rsel = '0;
        if (lo_i >= NIB_W'(REG_BASE)) begin
            info_o.mode = MODE_REG;
            info_o.rsel = lo_i[REG_W-1:0];
        end else if (lo_i >= NIB_W'(IND_BASE)) begin
            info_o.mode = MODE_IND;
            info_o.rsel = {{(REG_W-1){1'b0}}, lo_i[0]};
        end else if (lo_i == 4'h5) begin
            info_o.mode = MODE_DIR;
        end else if (lo_i == 4'h4) begin
            info_o.mode = col4_is_acc(cls_i) ? MODE_ACC : MODE_IMM;
        end else if (lo_i == 4'h3) begin
            info_o.mode = MODE_IMM;   // memory destination, immediate source
        end else begin
            info_o.mode = MODE_ACC;   // memory destination, accumulator source
        end
    end

    always_comb begin
        if (!$isunknown(lo_i)) begin
            if (info_o.mode == MODE_IND)
                assert_ind_reg_R2: assert (info_o.rsel <= 3'd1)
                    else $error("indirect register index out of range");
            if (info_o.mode == MODE_REG)
                assert_reg_col_R2: assert (lo_i[3])
                    else $error("register mode outside columns 8..F");
        end
    end

endmodule

// File: rtl/opc_grid_check.sv
module opc_grid_check
    import opc_grid_pkg::*;
(
    input  op_cls_e           cls_i,
    input  logic [NIB_W-1:0]  lo_i,
    input  opnd_mode_e        mode_i,
    output grid_info_t        info_o
);

    logic low_cols;
    logic mem_cell;

    assign low_cols = (lo_i < 4'h4);
    assign mem_cell = low_cols && is_logic_cls(cls_i) && (lo_i[NIB_W-1:1] == 3'b001);

    always_comb begin
        info_o            = '0;
        info_o.memform    = mem_cell;
        info_o.valid      = mem_cell || (!low_cols && !is_hole(cls_i, lo_i));
        if (info_o.valid) begin
            info_o.dst_mem    = mem_cell || (cls_i == CLS_MVTD) ||
                                (writes_operand(cls_i) && mode_i == MODE_DIR);
            info_o.flags_all  = (cls_i == CLS_ADD) || (cls_i == CLS_ADDC) ||
                                (cls_i == CLS_SUBB);
            info_o.carry_only = (cls_i == CLS_CJMP);
        end
    end

    always_comb begin
        if (!$isunknown(lo_i)) begin
            if (info_o.memform)
                assert_memform_dst_R5: assert (info_o.dst_mem && info_o.valid)
                    else $error("memory-destination form not writing memory");
            assert_flag_kind_R9: assert ($onehot0({info_o.flags_all, info_o.carry_only}))
                else $error("both flag kinds reported");
        end
    end

endmodule

// File: rtl/opc_len_calc.sv
module opc_len_calc
    import opc_grid_pkg::*;
(
    input  op_cls_e            cls_i,
    input  opnd_mode_e         mode_i,
    input  logic               valid_i,
    input  logic               memform_i,
    output logic [LEN_W-1:0]   len_o
);

    logic             opnd_byte;
    logic             class_byte;
    logic             second_imm;
    logic [SUM_W-1:0] total;

    assign opnd_byte  = (mode_i == MODE_DIR) || (mode_i == MODE_IMM);
    assign class_byte = memform_i ||
                        (cls_i == CLS_MVI)  || (cls_i == CLS_MVTD) ||
                        (cls_i == CLS_MVFD) || (cls_i == CLS_CJMP) ||
                        (cls_i == CLS_DJMP);
    assign second_imm = (cls_i == CLS_CJMP) && !opnd_byte;

    always_comb begin
        total = SUM_W'(1) + SUM_W'(opnd_byte) + SUM_W'(class_byte) + SUM_W'(second_imm);
        len_o = valid_i ? total[LEN_W-1:0] : '0;
    end

    always_comb begin
        if (!$isunknown({cls_i, mode_i, valid_i})) begin
            if (valid_i)
                assert_len_bound_R7: assert (total >= SUM_W'(1) && total <= SUM_W'(3))
                    else $error("instruction length out of range");
            if (valid_i && cls_i == CLS_CJMP)
                assert_cjmp_len_R7: assert (len_o == 2'd3)
                    else $error("compare-and-jump not three bytes");
        end
    end

endmodule

// File: rtl/opc_grid_decoder.sv
module opc_grid_decoder
    import opc_grid_pkg::*;
(
    input  logic [7:0] opcode_i,
    output logic       valid_o,
    output logic       irregular_o,
    output logic [3:0] op_class_o,
    output logic [2:0] src_mode_o,
    output logic [2:0] reg_sel_o,
    output logic       dst_mem_o,
    output logic [1:0] length_o,
    output logic       flags_all_o,
    output logic       carry_only_o
);

    op_cls_e          cls;
    logic [NIB_W-1:0] lo;
    opnd_info_t       opnd;
    grid_info_t       grid;
    logic [LEN_W-1:0] len;

    assign cls = op_cls_e'(opcode_i[OPC_W-1:NIB_W]);
    assign lo  = opcode_i[NIB_W-1:0];

    opc_mode_dec u_mode (
        .cls_i  (cls),
        .lo_i   (lo),
        .info_o (opnd)
    );

    opc_grid_check u_grid (
        .cls_i  (cls),
        .lo_i   (lo),
        .mode_i (opnd.mode),
        .info_o (grid)
    );

    opc_len_calc u_len (
        .cls_i     (cls),
        .mode_i    (opnd.mode),
        .valid_i   (grid.valid),
        .memform_i (grid.memform),
        .len_o     (len)
    );

    always_comb begin
        valid_o      = grid.valid;
        irregular_o  = !grid.valid;
        op_class_o   = grid.valid ? cls : '0;
        src_mode_o   = grid.valid ? opnd.mode : '0;
        reg_sel_o    = grid.valid ? opnd.rsel : '0;
        dst_mem_o    = grid.dst_mem;
        length_o     = len;
        flags_all_o  = grid.flags_all;
        carry_only_o = grid.carry_only;
    end

    always_comb begin
        if (!$isunknown(opcode_i)) begin
            assert_split_R10: assert (valid_o != irregular_o)
                else $error("valid and irregular not complementary");
            if (!valid_o)
                assert_quiet_R10: assert (length_o == 2'd0 && !dst_mem_o &&
                                          !flags_all_o && !carry_only_o)
                    else $error("outputs active for a non-regular opcode");
            if (valid_o)
                assert_len_nonzero_R7: assert (length_o != 2'd0)
                    else $error("valid opcode with zero length");
        end
    end

endmodule

// File: tb/test_opc_grid_decoder.sv
module test_opc_grid_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opc = 8'h00;
    logic       valid, irr, dmem, fall, fcar;
    logic [3:0] cls;
    logic [2:0] mode, rsel;
    logic [1:0] len;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done  = 1'b0;

    always #5 clk = ~clk;

    opc_grid_decoder i_opc_grid_decoder (
        .opcode_i     (opc),
        .valid_o      (valid),
        .irregular_o  (irr),
        .op_class_o   (cls),
        .src_mode_o   (mode),
        .reg_sel_o    (rsel),
        .dst_mem_o    (dmem),
        .length_o     (len),
        .flags_all_o  (fall),
        .carry_only_o (fcar)
    );

    // expected: {valid, irr, class4, mode3, reg3, dst, len2, fall, fcar}
    function automatic logic [16:0] model(input logic [7:0] op);
        logic [3:0] hi, lo;
        logic [2:0] m, r;
        logic [1:0] l;
        logic d, fa, fc;
        int extra;
        hi = op[7:4];
        lo = op[3:0];
        if (op inside {8'h42, 8'h52, 8'h62})            // R5
            return {1'b1, 1'b0, hi, 3'd0, 3'd0, 1'b1, 2'd2, 2'b00};
        if (op inside {8'h43, 8'h53, 8'h63})            // R5
            return {1'b1, 1'b0, hi, 3'd1, 3'd0, 1'b1, 2'd3, 2'b00};
        if (lo < 4'h4 ||
            op inside {8'h84, 8'hA4, 8'hA5, 8'hC4, 8'hD4, 8'hD6, 8'hD7, 8'hE4, 8'hF4})
            return {1'b0, 1'b1, 15'd0};                 // R6, R10
        r = 3'd0;
        if (lo >= 4'h8)      begin m = 3'd4; r = 3'(lo - 4'h8); end   // R2
        else if (lo >= 4'h6) begin m = 3'd3; r = 3'(lo - 4'h6); end   // R2
        else if (lo == 4'h5) m = 3'd2;                                // R3
        else m = (hi == 4'h0 || hi == 4'h1 || hi == 4'h7) ? 3'd0 : 3'd1; // R4
        extra = 1;                                                    // R7
        if (m == 3'd1 || m == 3'd2) extra++;
        if (hi inside {4'h7, 4'h8, 4'hA, 4'hB, 4'hD}) extra++;
        if (hi == 4'hB && (m == 3'd3 || m == 3'd4)) extra++;
        l = 2'(extra);
        d = (hi == 4'h8) ||
            (hi inside {4'h0, 4'h1, 4'h7, 4'hC, 4'hD, 4'hF} && m == 3'd2); // R8
        fa = hi inside {4'h2, 4'h3, 4'h9};                              // R9
        fc = (hi == 4'hB);
        return {1'b1, 1'b0, hi, m, r, d, l, fa, fc};
    endfunction

    function automatic string req_of(input logic [7:0] op);
        if (op inside {8'h42, 8'h43, 8'h52, 8'h53, 8'h62, 8'h63}) return "R5";
        if (op[3:0] < 4'h4 ||
            op inside {8'h84, 8'hA4, 8'hA5, 8'hC4, 8'hD4, 8'hD6, 8'hD7, 8'hE4, 8'hF4})
            return "R6";
        if (op[7:4] == 4'hB || op == 8'h85) return "R7";
        if (op[3:0] == 4'h4) return "R4";
        if (op[3:0] == 4'h5) return "R3";
        return "R2";
    endfunction

    task automatic check_op(input logic [7:0] op, input string tag);
        logic [16:0] got, exp;
        @(negedge clk);
        opc = op;
        #2;
        got = {valid, irr, cls, mode, rsel, dmem, len, fall, fcar};
        exp = model(op);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s/R1/R8/R9/R10 op=%02h actual=%05h expected=%05h",
                     tag, op, got, exp);
        end
    endtask

    initial begin
        int unsigned seed;
        logic [7:0] corner [14];
        corner = '{8'h04, 8'h14, 8'h74, 8'h24, 8'hB4, 8'hB5, 8'hB6, 8'h85,
                   8'h86, 8'hD5, 8'hD8, 8'h42, 8'h63, 8'hA5};
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-state / idle opcode 0x00 is irregular (R10)
        check_op(8'h00, "R10");
        // full sweep of every byte (R1..R10)
        for (int i = 0; i < 256; i++) check_op(8'(i), req_of(8'(i)));
        // directed corners: accumulator column, compare-and-jump, double direct
        for (int i = 0; i < 14; i++) check_op(corner[i], req_of(corner[i]));
        // seeded random bytes
        seed = 32'd7321;
        void'($urandom(seed));
        for (int i = 0; i < 1500; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            check_op(b, req_of(b));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R10 actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule